// File: doc/BRIEF.md
# Condition-Field Mask/Mode Predicate Unit

This execution unit owns a condition register of eight 4-bit fields and runs one predicate instruction per strobe. Every result bit comes from a masked equality test. A result bit is 1 only when its mask bit is 1 and its mode bit matches the source bit in the same position. The unit then either merges the result into a destination field or returns it on an integer result bus.

Three variants are implemented:

- **Field to field:** the source is another condition field.
- **Integer to field:** the single least significant bit of an integer operand feeds all four comparisons. A zero-register indicator forces that bit to 0.
- **Field to integer:** the 4-bit result lands in the low bits of a 64-bit bus.

A merge flag controls the write. When it is set, the unit performs a read-modify-write that preserves destination bits outside the mask. When it is clear, the unit performs a plain overwrite that zeroes those bits.

With integer to field and a zero operand, three mask/mode/merge settings act as shortcuts:

- set the masked bits;
- clear the masked bits;
- load an immediate pattern.

Top module: `cr_pred_unit`

## Requirements
- R1: While `rst_n` is low, all eight fields clear to 0, so `cr_o` reads 0 and `int_res_valid_o`, `int_res_o` and `illegal_o` read 0.
- R2: For each bit k of 0..3, the raw result is `mask_i[k] & (mode_i[k] == src[k])`. Field f occupies `cr_o[31-4f -: 4]`, so field 0 is the most significant nibble and field 7 the least. Nibble bit k of a field is bit k of that 4-bit slice.
- R3: With `variant_i` = 2'b11 (field to field), `src` is field `src_idx_i` and the result is written to field `dst_idx_i` at the clock edge where `valid_i` is high. `src_idx_i` may equal `dst_idx_i`.
- R4: With `variant_i` = 2'b01 (integer to field), every `src[k]` equals `int_op_i[0]`, and that bit is forced to 0 when `int_zero_i` is 1. The result is written to field `dst_idx_i`, and `src_idx_i` is ignored.
- R5: When `merge_i` is 1 on a field write, destination bits whose mask bit is 0 keep their previous value.
- R6: When `merge_i` is 0 on a field write, destination bits whose mask bit is 0 become 0.
- R7: With `variant_i` = 2'b00 (field to integer), the cycle after the strobe shows `int_res_valid_o` = 1, the raw result in `int_res_o[3:0]` and zeros above. No field changes, and `merge_i` has no effect. In every other cycle `int_res_o` is 0 and `int_res_valid_o` is 0.
- R8: A strobe with `variant_i` = 2'b10 changes no field and raises `illegal_o` for exactly the following cycle.
- R9: While `valid_i` is low, no field changes and both flags stay low, whatever the other inputs carry.
- R10: An instruction sees the fields as updated by the instruction one cycle earlier, so back-to-back dependent instructions need no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| valid_i | input | 1 | Instruction strobe |
| variant_i | input | 2 | 00 field to integer, 01 integer to field, 10 unimplemented, 11 field to field |
| dst_idx_i | input | 3 | Destination field index |
| src_idx_i | input | 3 | Source field index |
| mask_i | input | 4 | Per-bit enable of the test |
| mode_i | input | 4 | Per-bit value the source must equal |
| merge_i | input | 1 | 1 keeps unmasked destination bits, 0 zeroes them |
| int_op_i | input | 64 | Integer operand |
| int_zero_i | input | 1 | Operand register is index 0, so the value is zero |
| cr_o | output | 32 | Whole condition register, field 0 in bits 31:28 |
| int_res_o | output | 64 | Field-to-integer result |
| int_res_valid_o | output | 1 | Integer result present |
| illegal_o | output | 1 | Unimplemented variant seen |

## Verification
The integer-to-field shortcuts are tried with a zero operand:

- Set and clear, with merge on. These show that unmasked bits survive the merge.
- An immediate load, with merge off and the full mask. This shows that the inverted mode becomes the field value.

An odd integer paired with the zero-register indicator tells the indicator apart from the operand's low bit.

Field-to-field cases cover four situations:

- all-match;
- partial mask with overwrite, which separates merge from overwrite;
- a source equal to the destination;
- a read of a field written the cycle before.

A long stream of mixed variants and idle cycles with random operands then compares every cycle against a reference model.

// File: rtl/cr_pred_pkg.sv
package cr_pred_pkg;
  // Instruction variant encoding (two select bits of the instruction)
  typedef enum logic [1:0] {
    V_CR2INT  = 2'b00,
    V_INT2CR  = 2'b01,
    V_UNIMPL  = 2'b10,
    V_CR2CR   = 2'b11
  } variant_e;
endpackage

// File: rtl/cr_pred_file.sv
module cr_pred_file #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  localparam int IDX_W     = $clog2(NUM_FIELDS),
  localparam int CR_W      = NUM_FIELDS * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_a_idx,
  input  logic [IDX_W-1:0]   rd_b_idx,
  output logic [FIELD_W-1:0] rd_a,
  output logic [FIELD_W-1:0] rd_b,
  output logic [CR_W-1:0]    flat
);
  logic [FIELD_W-1:0] field_q [NUM_FIELDS];
  logic [FIELD_W-1:0] field_d [NUM_FIELDS];

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    always_comb begin
      field_d[f] = field_q[f];
      if (we && (wr_idx == IDX_W'(f))) field_d[f] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) field_q[f] <= '0;
      else        field_q[f] <= field_d[f];
    end

    // field 0 occupies the most significant slice
    assign flat[CR_W-1-f*FIELD_W -: FIELD_W] = field_q[f];
  end

  assign rd_a = field_q[rd_a_idx];
  assign rd_b = field_q[rd_b_idx];
endmodule

// File: rtl/cr_pred_eval.sv
module cr_pred_eval #(
  parameter int FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] src,
  input  logic [FIELD_W-1:0] mask,
  input  logic [FIELD_W-1:0] mode,
  output logic [FIELD_W-1:0] res
);
  for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
    assign res[k] = mask[k] & ~(mode[k] ^ src[k]);
  end
endmodule

// File: rtl/cr_pred_merge.sv
module cr_pred_merge #(
  parameter int FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] res,
  input  logic [FIELD_W-1:0] old,
  input  logic [FIELD_W-1:0] mask,
  input  logic               merge,
  output logic [FIELD_W-1:0] out
);
  always_comb begin
    out = res;
    if (merge) out = res | (old & ~mask);
  end
endmodule

// File: rtl/cr_pred_unit.sv
module cr_pred_unit
  import cr_pred_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  parameter int XLEN       = 64,
  localparam int IDX_W     = $clog2(NUM_FIELDS),
  localparam int CR_W      = NUM_FIELDS * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [1:0]         variant_i,
  input  logic [IDX_W-1:0]   dst_idx_i,
  input  logic [IDX_W-1:0]   src_idx_i,
  input  logic [FIELD_W-1:0] mask_i,
  input  logic [FIELD_W-1:0] mode_i,
  input  logic               merge_i,
  input  logic [XLEN-1:0]    int_op_i,
  input  logic               int_zero_i,
  output logic [CR_W-1:0]    cr_o,
  output logic [XLEN-1:0]    int_res_o,
  output logic               int_res_valid_o,
  output logic               illegal_o
);
  variant_e           op;
  logic [FIELD_W-1:0] src_field, old_field, src_sel, raw_res, wr_data;
  logic               int_bit, wr_en;
  logic [XLEN-1:0]    int_res_d, int_res_q;
  logic               int_vld_d, int_vld_q, ill_d, ill_q;

  assign op = variant_e'(variant_i);

  cr_pred_file #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_file (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_en),
    .wr_idx   (dst_idx_i),
    .wr_data  (wr_data),
    .rd_a_idx (src_idx_i),
    .rd_b_idx (dst_idx_i),
    .rd_a     (src_field),
    .rd_b     (old_field),
    .flat     (cr_o)
  );

  // integer operand: register index zero reads as value zero
  assign int_bit = int_zero_i ? 1'b0 : int_op_i[0];
  assign src_sel = (op == V_INT2CR) ? {FIELD_W{int_bit}} : src_field;

  cr_pred_eval #(.FIELD_W(FIELD_W)) u_eval (
    .src  (src_sel),
    .mask (mask_i),
    .mode (mode_i),
    .res  (raw_res)
  );

  cr_pred_merge #(.FIELD_W(FIELD_W)) u_merge (
    .res   (raw_res),
    .old   (old_field),
    .mask  (mask_i),
    .merge (merge_i),
    .out   (wr_data)
  );

  assign wr_en = valid_i && ((op == V_INT2CR) || (op == V_CR2CR));

  always_comb begin
    int_vld_d = valid_i && (op == V_CR2INT);
    int_res_d = int_vld_d ? XLEN'(raw_res) : '0;
    ill_d     = valid_i && (op == V_UNIMPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_res_q <= '0;
      int_vld_q <= 1'b0;
      ill_q     <= 1'b0;
    end else begin
      int_res_q <= int_res_d;
      int_vld_q <= int_vld_d;
      ill_q     <= ill_d;
    end
  end

  assign int_res_o       = int_res_q;
  assign int_res_valid_o = int_vld_q;
  assign illegal_o       = ill_q;
endmodule

// File: rtl/cr_pred_chk.sv
module cr_pred_chk #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  parameter int XLEN       = 64,
  localparam int IDX_W     = $clog2(NUM_FIELDS),
  localparam int CR_W      = NUM_FIELDS * FIELD_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               valid_i,
  input logic [1:0]         variant_i,
  input logic [IDX_W-1:0]   dst_idx_i,
  input logic [FIELD_W-1:0] mask_i,
  input logic [FIELD_W-1:0] mode_i,
  input logic               merge_i,
  input logic [XLEN-1:0]    int_op_i,
  input logic               int_zero_i,
  input logic [CR_W-1:0]    cr_o,
  input logic [XLEN-1:0]    int_res_o,
  input logic               int_res_valid_o,
  input logic               illegal_o
);
  function automatic logic [FIELD_W-1:0] fld(input logic [CR_W-1:0] cr, input logic [IDX_W-1:0] idx);
    return cr[CR_W-1-int'(idx)*FIELD_W -: FIELD_W];
  endfunction

  logic field_wr;
  assign field_wr = valid_i && (variant_i == 2'b01 || variant_i == 2'b11);

  p_keep_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    field_wr && merge_i |=>
      ((fld(cr_o, $past(dst_idx_i)) & ~$past(mask_i)) ==
       (fld($past(cr_o), $past(dst_idx_i)) & ~$past(mask_i))));

  p_zero_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    field_wr && !merge_i |=> ((fld(cr_o, $past(dst_idx_i)) & ~$past(mask_i)) == '0));

  p_int2cr_uniform_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && variant_i == 2'b01 && !merge_i && (&mask_i) |=>
      fld(cr_o, $past(dst_idx_i)) ==
        (($past(int_zero_i) ? 1'b0 : $past(int_op_i[0])) ? $past(mode_i) : ~$past(mode_i)));

  p_cr2int_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && variant_i == 2'b00 |=> int_res_valid_o && cr_o == $past(cr_o));

  p_int_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_res_o[XLEN-1:FIELD_W] == '0);

  p_illegal_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && variant_i == 2'b10 |=> illegal_o && !int_res_valid_o && cr_o == $past(cr_o));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !illegal_o && !int_res_valid_o && $stable(cr_o));
endmodule

bind cr_pred_unit cr_pred_chk #(
  .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .XLEN(XLEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .variant_i(variant_i),
  .dst_idx_i(dst_idx_i), .mask_i(mask_i), .mode_i(mode_i), .merge_i(merge_i),
  .int_op_i(int_op_i), .int_zero_i(int_zero_i), .cr_o(cr_o),
  .int_res_o(int_res_o), .int_res_valid_o(int_res_valid_o), .illegal_o(illegal_o)
);

// File: tb/cr_pred_unit_test.sv
module cr_pred_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [1:0]  variant_i;
  logic [2:0]  dst_idx_i, src_idx_i;
  logic [3:0]  mask_i, mode_i;
  logic        merge_i;
  logic [63:0] int_op_i;
  logic        int_zero_i;
  logic [31:0] cr_o;
  logic [63:0] int_res_o;
  logic        int_res_valid_o, illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] cr;
    logic [63:0] ires;
    logic        ivld;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] mcr;

  always #10 clk = ~clk;

  cr_pred_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .variant_i(variant_i),
    .dst_idx_i(dst_idx_i), .src_idx_i(src_idx_i), .mask_i(mask_i), .mode_i(mode_i),
    .merge_i(merge_i), .int_op_i(int_op_i), .int_zero_i(int_zero_i), .cr_o(cr_o),
    .int_res_o(int_res_o), .int_res_valid_o(int_res_valid_o), .illegal_o(illegal_o)
  );

  function automatic logic [3:0] fld(input logic [31:0] cr, input int i);
    return cr[31-4*i -: 4];
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: applies one instruction and queues the expected post-edge state
  task automatic issue(input logic v, input logic [1:0] var_c, input int dst, input int src,
                       input logic [3:0] mask, input logic [3:0] mode, input logic mrg,
                       input logic [63:0] op, input logic z, input string tag);
    exp_t e;
    logic [3:0] s, r, nw;
    @(negedge clk);
    valid_i = v; variant_i = var_c; dst_idx_i = 3'(dst); src_idx_i = 3'(src);
    mask_i = mask; mode_i = mode; merge_i = mrg; int_op_i = op; int_zero_i = z;
    if (var_c == 2'b01) s = {4{(z ? 1'b0 : op[0])}};
    else                s = fld(mcr, src);
    for (int k = 0; k < 4; k++) r[k] = mask[k] && (mode[k] == s[k]);
    if (v && (var_c == 2'b01 || var_c == 2'b11)) begin
      nw = mrg ? (r | (fld(mcr, dst) & ~mask)) : r;
      mcr[31-4*dst -: 4] = nw;
    end
    e.cr   = mcr;
    e.ivld = v && (var_c == 2'b00);
    e.ires = e.ivld ? {60'b0, r} : 64'b0;
    e.ill  = v && (var_c == 2'b10);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.tag, "cr_o", {32'b0, cr_o}, {32'b0, e.cr});
        chk(e.tag, "int_res_o", int_res_o, e.ires);
        chk(e.tag, "int_res_valid_o", {63'b0, int_res_valid_o}, {63'b0, e.ivld});
        chk(e.tag, "illegal_o", {63'b0, illegal_o}, {63'b0, e.ill});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid_i = 0; variant_i = 0; dst_idx_i = 0; src_idx_i = 0;
    mask_i = 0; mode_i = 0; merge_i = 0; int_op_i = 0; int_zero_i = 0;
    mcr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cr_o", {32'b0, cr_o}, 64'b0);
    chk("R1", "int_res_o", int_res_o, 64'b0);
    chk("R1", "flags", {62'b0, int_res_valid_o, illegal_o}, 64'b0);
    rst_n = 1'b1;

    // R4: immediate load via inverted mode, zero register -> field 0 = 0xA
    issue(1, 2'b01, 0, 5, 4'hF, 4'h5, 0, 64'h1, 1, "R4_imm");
    // R4: operand LSB 1 -> field 3 = mode
    issue(1, 2'b01, 3, 0, 4'hF, 4'h6, 0, 64'h8000_0000_0000_0001, 0, "R4_lsb");
    // R5: set masked bits (zero operand, mode 0000) -> 0xF
    issue(1, 2'b01, 0, 0, 4'h5, 4'h0, 1, 64'h0, 1, "R5_set");
    // R5: clear masked bits (mode 1111) -> 0xC
    issue(1, 2'b01, 0, 0, 4'h3, 4'hF, 1, 64'h0, 1, "R5_clr");
    // R4: even operand vs odd operand masked by zero indicator
    issue(1, 2'b01, 1, 0, 4'hF, 4'h0, 0, 64'hFFFF_FFFF_FFFF_FFFE, 0, "R4_even");
    issue(1, 2'b01, 2, 0, 4'hF, 4'h0, 0, 64'h3, 1, "R4_zero");
    // R3: field to field all-match
    issue(1, 2'b11, 5, 0, 4'hF, 4'hC, 0, 64'h0, 0, "R3_match");
    // R6: partial mask overwrite
    issue(1, 2'b11, 5, 3, 4'h9, 4'h0, 0, 64'h0, 0, "R6_over");
    // R5: merge keeps 0x9 bits
    issue(1, 2'b11, 5, 3, 4'h6, 4'hF, 1, 64'h0, 0, "R5_merge");
    // R3: source equals destination
    issue(1, 2'b11, 5, 5, 4'h1, 4'h0, 1, 64'h0, 0, "R3_self");
    // R2: field 7 lands in the least significant nibble
    issue(1, 2'b01, 7, 0, 4'hF, 4'hB, 0, 64'h1, 0, "R2_f7");
    // R10: dependent back-to-back read of field 7
    issue(1, 2'b11, 6, 7, 4'hF, 4'hB, 0, 64'h0, 0, "R10_fwd");
    // R7: field to integer, merge ignored, no field written
    issue(1, 2'b00, 0, 3, 4'hF, 4'h6, 1, 64'h0, 0, "R7_c2i");
    // R8: unimplemented variant
    issue(1, 2'b10, 0, 3, 4'hF, 4'h0, 0, 64'h1, 0, "R8_ill");
    // R9: idle with junk
    issue(0, 2'b11, 0, 1, 4'hF, 4'h3, 0, 64'hFF, 0, "R9_idle");
    issue(0, 2'b01, 4, 1, 4'hF, 4'h0, 1, 64'h0, 1, "R9_idle");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      issue(a[0] | a[1], a[3:2], int'(a[6:4]), int'(a[9:7]), a[13:10], a[17:14],
            a[18], {b, b}, a[19], "R2_mix");
    end
    issue(0, 2'b00, 0, 0, 4'h0, 4'h0, 0, 64'h0, 0, "R9_drain");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule